// File: doc/BRIEF.md
# Shadow-Buffered Single-Channel PWM

This block produces one pulse-width-modulated output from a timestamp counter. The counter runs from zero up to an active period value and then wraps. Each period the output is set by comparing the counter with an active compare value. Software sets it up through a small register file on a simple request bus. That bus carries request, write-enable, byte address, write data and registered read data.

While the counter runs, new period and compare values go to separate shadow registers. They move into the active registers only on the wrap cycle, so the period in progress always finishes with its old values. While the counter is stopped, shadow writes are mirrored into the active registers at once, so a value written then is not lost. Control bits select the run state, the output mode, the output polarity and whether an external sync pulse may restart the counter. When the output mode is off, the output is held low.

Top module: `shadow_pwm`

## Requirements
- R1: After reset every register reads 0, the counter is 0 and `pwm_o` is low.
- R2: Register map (byte address): 0x08 active period, 0x0C active compare, 0x10 shadow period, 0x14 shadow compare (all 32 bits), and 0x2A control (16 bits, taken from `bus_wdata_i[15:0]`, read zero-extended). A read request returns its data on `bus_rdata_o` after the next clock edge. Unmapped addresses read 0.
- R3: The control register holds its fields at these bit positions: bit 4 runs the counter, bits 7:6 both set disables sync, bit 9 enables the output mode, and bit 10 inverts polarity. Every written bit reads back.
- R4: While running, the counter steps by one each cycle from 0 to the active period and then returns to 0. A period value P therefore gives an output pattern of P+1 cycles.
- R5: `pwm_o` is registered and reflects the counter state of the previous cycle. With normal polarity it is high while counter < compare. A compare of 0 gives a constant low, and a compare above the period gives a constant high.
- R6: With bit 10 set, the level from R5 is inverted, so the compare value sets the low time.
- R7: With bit 9 clear, `pwm_o` is low whatever the polarity, counter and compare values.
- R8: While running, a shadow write leaves the matching active register unchanged until the next wrap cycle. On that cycle the active register takes the shadow value, but only if that shadow register was written since the last transfer.
- R9: A write to an active register takes effect at once. A shadow write made while stopped is also copied into the matching active register at once.
- R10: While bit 4 is clear the counter is held at 0, so setting bit 4 again always starts a fresh period from 0.
- R11: While running with bits 7:6 not both set, `sync_i` high restarts the counter at 0 on the next edge, with no shadow transfer. With both bits set, `sync_i` is ignored.
- R12: A period of 1 with a compare of 1 gives an output that alternates high and low on every cycle, with no cycle held twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid after the edge following a read request |
| sync_i | input | 1 | External counter restart |
| pwm_o | output | 1 | PWM output |

## Verification
The counter-step and shadow-hold properties assume that no bus write reaches the active period register on the cycle being checked. The shadow-hold property excludes such writes in its antecedent. The bench keeps phase-sensitive shadow checks safe by first stopping the counter and loading a 200-cycle period, so no wrap can fall between the shadow writes and the read-back. The readback property assumes a read request carries no simultaneous write. The bench never asserts request with write-enable for a read. It drives `sync_i` only as single-cycle pulses at known counter phases.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;
  localparam logic [7:0] ADR_PER_ACT = 8'h08;
  localparam logic [7:0] ADR_CMP_ACT = 8'h0C;
  localparam logic [7:0] ADR_PER_SH  = 8'h10;
  localparam logic [7:0] ADR_CMP_SH  = 8'h14;
  localparam logic [7:0] ADR_CTRL    = 8'h2A;

  localparam int B_RUN     = 4;
  localparam int B_SDIS_LO = 6;
  localparam int B_SDIS_HI = 7;
  localparam int B_MODE    = 9;
  localparam int B_POL     = 10;

  localparam int N_SLOT   = 2;
  localparam int SLOT_PER = 0;
  localparam int SLOT_CMP = 1;
endpackage

// File: rtl/shadow_pwm_regs.sv
module shadow_pwm_regs
  import shadow_pwm_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wrap_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] per_o,
  output logic [DW-1:0] cmp_o,
  output logic [CW-1:0] ctrl_o
);
  logic          wr;
  logic          run;
  logic [CW-1:0] ctrl_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] act_all [N_SLOT];
  logic [DW-1:0] sh_all  [N_SLOT];

  assign wr  = req_i & we_i;
  assign run = ctrl_q[B_RUN];

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    localparam logic [AW-1:0] A_ACT = AW'(i == SLOT_PER ? ADR_PER_ACT : ADR_CMP_ACT);
    localparam logic [AW-1:0] A_SH  = AW'(i == SLOT_PER ? ADR_PER_SH  : ADR_CMP_SH);
    logic [DW-1:0] act_q, sh_q;
    logic          pend_q;
    logic          wr_act, wr_sh;

    assign wr_act = wr && (addr_i == A_ACT);
    assign wr_sh  = wr && (addr_i == A_SH);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q  <= '0;
        sh_q   <= '0;
        pend_q <= 1'b0;
      end else begin
        if (wr_sh) sh_q <= wdata_i;
        // direct write beats mirror, mirror beats boundary transfer
        if (wr_act)                 act_q <= wdata_i;
        else if (wr_sh && !run)     act_q <= wdata_i;
        else if (wrap_i && pend_q)  act_q <= sh_q;
        if (wr_sh)       pend_q <= run;
        else if (wrap_i) pend_q <= 1'b0;
      end
    end

    assign act_all[i] = act_q;
    assign sh_all[i]  = sh_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr && addr_i == AW'(ADR_CTRL)) ctrl_q <= wdata_i[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (req_i && !we_i) begin
      case (addr_i)
        AW'(ADR_PER_ACT): rdata_q <= act_all[SLOT_PER];
        AW'(ADR_CMP_ACT): rdata_q <= act_all[SLOT_CMP];
        AW'(ADR_PER_SH):  rdata_q <= sh_all[SLOT_PER];
        AW'(ADR_CMP_SH):  rdata_q <= sh_all[SLOT_CMP];
        AW'(ADR_CTRL):    rdata_q <= {{(DW-CW){1'b0}}, ctrl_q};
        default:          rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign per_o   = act_all[SLOT_PER];
  assign cmp_o   = act_all[SLOT_CMP];
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/shadow_pwm_counter.sv
module shadow_pwm_counter #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          sync_i,
  input  logic          sync_dis_i,
  input  logic [DW-1:0] period_i,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [DW-1:0] cnt_q;
  logic          sync_hit;
  logic          at_end;

  assign sync_hit = run_i & ~sync_dis_i & sync_i;
  // >= covers a period lowered below the count by a direct write
  assign at_end   = cnt_q >= period_i;
  assign wrap_o   = run_i & ~sync_hit & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!run_i || sync_hit || at_end) cnt_q <= '0;
    else                                   cnt_q <= cnt_q + DW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/shadow_pwm_outgen.sv
module shadow_pwm_outgen #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] cmp_i,
  input  logic          mode_i,
  input  logic          pol_i,
  output logic          pwm_o
);
  logic active, lvl, pwm_q;

  assign active = cnt_i < cmp_i;
  assign lvl    = pol_i ? ~active : active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= mode_i & lvl;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import shadow_pwm_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          sync_i,
  output logic          pwm_o
);
  logic [DW-1:0] per_w, cmp_w, cnt_w;
  logic [CW-1:0] ctrl_w;
  logic          wrap_w;

  shadow_pwm_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (bus_req_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .wrap_i  (wrap_w),
    .rdata_o (bus_rdata_o),
    .per_o   (per_w),
    .cmp_o   (cmp_w),
    .ctrl_o  (ctrl_w)
  );

  shadow_pwm_counter #(.DW(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl_w[B_RUN]),
    .sync_i     (sync_i),
    .sync_dis_i (&ctrl_w[B_SDIS_HI:B_SDIS_LO]),
    .period_i   (per_w),
    .cnt_o      (cnt_w),
    .wrap_o     (wrap_w)
  );

  shadow_pwm_outgen #(.DW(DW)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt_w),
    .cmp_i  (cmp_w),
    .mode_i (ctrl_w[B_MODE]),
    .pol_i  (ctrl_w[B_POL]),
    .pwm_o  (pwm_o)
  );
endmodule

// File: rtl/shadow_pwm_chk.sv
module shadow_pwm_chk
  import shadow_pwm_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_i,
  input logic          bus_we_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_rdata_o,
  input logic          sync_i,
  input logic          pwm_o,
  input logic [CW-1:0] ctrl,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] per
);
  logic run, sdis, per_wr;
  assign run    = ctrl[B_RUN];
  assign sdis   = &ctrl[B_SDIS_HI:B_SDIS_LO];
  assign per_wr = bus_req_i && bus_we_i && (bus_addr_i == AW'(ADR_PER_ACT));

  // R7
  mode_off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[B_MODE] |=> !pwm_o);

  // R10
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> cnt == '0);

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt < per && !(sync_i && !sdis)) |=> cnt == $past(cnt) + DW'(1));

  // R11
  sync_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && sdis && cnt < per) |=> cnt == $past(cnt) + DW'(1));

  // R11
  sync_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !sdis && sync_i) |=> cnt == '0);

  // R8
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt < per && !per_wr) |=> $stable(per));

  // R2
  ctrl_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i == AW'(ADR_CTRL))
      |=> bus_rdata_o == {{(DW-CW){1'b0}}, $past(ctrl)});
endmodule

bind shadow_pwm shadow_pwm_chk #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .sync_i      (sync_i),
  .pwm_o       (pwm_o),
  .ctrl        (ctrl_w),
  .cnt         (cnt_w),
  .per         (per_w)
);

// File: tb/sim_shadow_pwm.sv
`timescale 1ns/1ps
module sim_shadow_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sync = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  shadow_pwm u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sync_i(sync), .pwm_o(pwm)
  );

  // behavioural reference
  logic [31:0] m_per, m_cmp, m_psh, m_csh, m_cnt;
  logic [15:0] m_ctrl;
  bit m_pp, m_pc, m_out;

  always @(posedge clk or negedge rst_n) begin
    bit run, hit, wrap, w;
    logic [31:0] nper, ncmp;
    if (!rst_n) begin
      m_per = 0; m_cmp = 0; m_psh = 0; m_csh = 0; m_cnt = 0;
      m_ctrl = 0; m_pp = 0; m_pc = 0; m_out = 0;
    end else begin
      run  = m_ctrl[4];
      hit  = run && (m_ctrl[7:6] != 2'b11) && sync;
      wrap = run && !hit && (m_cnt >= m_per);
      w    = req && we;
      m_out = m_ctrl[9] && (m_ctrl[10] ? !(m_cnt < m_cmp) : (m_cnt < m_cmp));
      nper = m_per; ncmp = m_cmp;
      if (w && addr == 8'h08) nper = wdata;
      else if (w && addr == 8'h10 && !run) nper = wdata;
      else if (wrap && m_pp) nper = m_psh;
      if (w && addr == 8'h0C) ncmp = wdata;
      else if (w && addr == 8'h14 && !run) ncmp = wdata;
      else if (wrap && m_pc) ncmp = m_csh;
      if (w && addr == 8'h10) begin m_psh = wdata; m_pp = run; end
      else if (wrap) m_pp = 0;
      if (w && addr == 8'h14) begin m_csh = wdata; m_pc = run; end
      else if (wrap) m_pc = 0;
      m_cnt = (!run || hit || m_cnt >= m_per) ? 0 : m_cnt + 1;
      m_per = nper; m_cmp = ncmp;
      if (w && addr == 8'h2A) m_ctrl = wdata[15:0];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (pwm !== m_out) begin
        n_fail++;
        $display("FAIL %s cycle %0d: pwm_o actual %0b expected %0b", cur_req, cyc, pwm, m_out);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string r);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    chk(rdata === exp, r, int'(rdata), int'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic highs(input int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); h += int'(pwm); end
  endtask

  initial begin
    int h;
    bit prev;
    idle(3);
    rst_n = 1;
    chk(pwm === 1'b0, "R1", int'(pwm), 0);
    rd(8'h2A, 0, "R1");
    rd(8'h08, 0, "R1");
    rd(8'h14, 0, "R1");

    cur_req = "R9";
    wr(8'h08, 9); wr(8'h0C, 4);
    rd(8'h08, 9, "R9"); rd(8'h0C, 4, "R2");
    rd(8'h20, 0, "R2");
    wr(8'h2A, 32'hFFFF_02D0);
    rd(8'h2A, 32'h02D0, "R3");

    cur_req = "R5";
    idle(30); highs(10, h); chk(h == 4, "R5 high time", h, 4);
    cur_req = "R6";
    wr(8'h2A, 32'h06D0); idle(12); highs(10, h); chk(h == 6, "R6 inverted", h, 6);

    cur_req = "R8";
    wr(8'h2A, 32'h02C0); wr(8'h08, 200); wr(8'h0C, 100);
    wr(8'h2A, 32'h02D0);
    wr(8'h10, 5); wr(8'h14, 2);
    rd(8'h08, 200, "R8 held"); rd(8'h0C, 100, "R8 held");
    rd(8'h10, 5, "R2");
    idle(250);
    rd(8'h08, 5, "R8 transferred"); rd(8'h0C, 2, "R8 transferred");
    idle(6); highs(6, h); chk(h == 2, "R8 new shape", h, 2);

    cur_req = "R5";
    wr(8'h0C, 0); idle(3); highs(6, h); chk(h == 0, "R5 cmp zero", h, 0);
    wr(8'h0C, 20); idle(3); highs(6, h); chk(h == 6, "R5 cmp above period", h, 6);

    cur_req = "R12";
    wr(8'h08, 1); wr(8'h0C, 1); idle(4);
    @(negedge clk); prev = pwm; h = int'(pwm);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      chk(pwm !== prev, "R12 alternation", int'(pwm), int'(!prev));
      prev = pwm; h += int'(pwm);
    end
    chk(h == 4, "R12 duty", h, 4);

    cur_req = "R7";
    wr(8'h2A, 32'h00D0); idle(2); highs(10, h); chk(h == 0, "R7 mode off", h, 0);
    wr(8'h2A, 32'h04D0); idle(2); highs(10, h); chk(h == 0, "R7 mode off inverted", h, 0);

    cur_req = "R11";
    wr(8'h2A, 32'h02C0); wr(8'h08, 9); wr(8'h0C, 4);
    wr(8'h2A, 32'h0210);
    idle(6);
    sync = 1; @(negedge clk); sync = 0;
    @(negedge clk); chk(pwm === 1'b1, "R11 restart", int'(pwm), 1);
    h = int'(pwm);
    repeat (9) begin @(negedge clk); h += int'(pwm); end
    chk(h == 4, "R11 fresh period", h, 4);
    wr(8'h2A, 32'h02D0); idle(3);
    sync = 1; @(negedge clk); sync = 0;
    idle(25);

    cur_req = "R10";
    wr(8'h2A, 32'h02C0); idle(2); highs(5, h); chk(h == 5, "R10 held at zero", h, 5);
    cur_req = "R9";
    wr(8'h10, 7); rd(8'h08, 7, "R9 mirror");
    wr(8'h14, 3); rd(8'h0C, 3, "R9 mirror");
    cur_req = "R4";
    wr(8'h2A, 32'h02D0);
    highs(8, h); chk(h == 3, "R4 period length", h, 3);
    highs(8, h); chk(h == 3, "R4 repeat", h, 3);
    idle(10);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule